// File: doc/BRIEF.md
# Pulse-Width Modulator with Queued Duty Updates

This block generates a pulse-width modulated output from a free-running counter. The counter climbs from zero to a programmable terminal value and then starts again, so one period lasts the terminal value plus one clock cycles. The output is high at the start of each period and drops once the counter reaches the active duty value. It stays low for the rest of that period.

Duty values are never applied directly. Each value written on the sample port joins a four-entry queue. The head of the queue moves into the active compare register only at the end of a period. If the queue is empty at that moment, the active value is kept for the next period. The period value is double-buffered in the same way.

Because of this, a write can never change the compare value in the middle of a period. This matters most when a smaller duty is written after the counter has already passed it: applied at once, it would skip the falling edge and give a pulse that stays high for the whole period. Software can read the live counter, a saturating occupancy code, a sticky overflow flag and a free-space flag set against a programmable watermark.

Top module: `duty_fifo_pwm`

## Requirements
- R1: After reset the counter reads 0, the occupancy code is 0, the overflow flag is 0 and, with the enable low, the output is low.
- R2: While enabled, the counter steps by one each cycle from 0 up to the active terminal value, then returns to 0, so a period lasts terminal+1 cycles. The counter is visible on `count_o`.
- R3: Within a period the output is high while the counter is below the active sample and low from the match onward. A sample of 0 gives a low output for the whole period. A sample larger than the terminal value gives a high output for the whole period.
- R4: Sample writes join a queue of four entries. At each period end, if the queue holds anything, the oldest entry becomes the active sample, so values are applied in write order, one per period.
- R5: If the queue is empty when a period ends, the active sample is unchanged for the next period.
- R6: A sample written in the middle of a period does not alter the current period, even when the queue is empty and the new value is below the current counter. The output still falls at the old match point, and the new value first applies in the following period.
- R7: `fill_lvl` encodes occupancy as 0 = empty, 1 = one entry, 2 = two entries, 3 = three or four entries.
- R8: A sample write made while four entries are queued is discarded and sets `ovf_o`. The flag stays set until reset, and the queued entries and their order are not disturbed.
- R9: `room_o` is 1 exactly when the occupancy is less than or equal to the 2-bit watermark input.
- R10: A terminal-value write made while enabled takes effect at the next period end, so the running period keeps its length. While disabled, a written value is active within two cycles.
- R11: When the enable is low, the output is low in that same cycle and the counter is 0 from the next cycle. Queued entries are retained. On re-enable, counting restarts at 0 with the active sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low clears the counter and forces the output low |
| smp_we | input | 1 | Sample write strobe |
| smp_wdata | input | 16 | Sample value to queue |
| per_we | input | 1 | Terminal-value write strobe |
| per_wdata | input | 16 | Terminal value (period = value + 1 cycles) |
| wmark | input | 2 | Watermark for the free-space flag |
| count_o | output | 16 | Live counter value |
| fill_lvl | output | 2 | Saturating queue occupancy code |
| room_o | output | 1 | High when occupancy is at or below the watermark |
| ovf_o | output | 1 | Sticky flag: a write hit a full queue |
| pwm_o | output | 1 | Modulated output |

## Verification
The hardest situation to reach from the ports is a duty decrease that arrives with an empty queue after the counter has already passed the new value. The bench first settles a large active sample and lets the queue drain. It then writes a much smaller value exactly at a chosen counter position past that value, tracking the live counter to place the write. It checks that the current period still falls at the old match point and that the next period uses the new value. A full queue is built up with the enable held low, so that no period end can pop an entry. The bench then checks the saturating occupancy code, the watermark flag and the dropped fifth write. Finally it re-enables the generator and confirms that the retained entries are applied one per period, in write order.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_ONE   = 2'd1,
    FILL_TWO   = 2'd2,
    FILL_MANY  = 2'd3
  } fill_e;

  // Saturating occupancy code: three or more entries share one code.
  function automatic fill_e fill_code(input int unsigned occ);
    fill_e code;
    case (occ)
      0:       code = FILL_EMPTY;
      1:       code = FILL_ONE;
      2:       code = FILL_TWO;
      default: code = FILL_MANY;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop_req,
  output logic [DW-1:0]                head_data,
  output logic                         head_valid,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         ovf
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_n;
  logic [OCC_W-1:0] occ_q, occ_n;
  logic             ovf_q, ovf_n;
  logic             full, empty, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ_q == OCC_W'(DEPTH));
  assign empty   = (occ_q == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    occ_n    = occ_q;
    ovf_n    = ovf_q;
    if (push_ok) wr_ptr_n = ptr_inc(wr_ptr_q);
    if (pop_ok)  rd_ptr_n = ptr_inc(rd_ptr_q);
    case ({push_ok, pop_ok})
      2'b10:   occ_n = occ_q + 1'b1;
      2'b01:   occ_n = occ_q - 1'b1;
      default: occ_n = occ_q;
    endcase
    if (push_req && full) ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      occ_q    <= occ_n;
      ovf_q    <= ovf_n;
    end
  end

  // Storage carries no reset; only entries below the occupancy are read.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  assign head_data  = mem[rd_ptr_q];
  assign head_valid = !empty;
  assign occ        = occ_q;
  assign ovf        = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> (occ_q == OCC_W'(DEPTH))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !empty) |=> (occ_q == $past(occ_q) - 1'b1)); // R4

endmodule

// File: rtl/pwmq_timebase.sv
module pwmq_timebase #(
  parameter int unsigned   CW         = 16,
  parameter logic [CW-1:0] RST_PERIOD = 16'd255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          per_we,
  input  logic [CW-1:0] per_wdata,
  output logic [CW-1:0] cnt,
  output logic          boundary
);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] per_pend_q, per_pend_n;
  logic [CW-1:0] per_act_q, per_act_n;

  assign boundary = en && (cnt_q == per_act_q);

  always_comb begin
    per_pend_n = per_we ? per_wdata : per_pend_q;
    per_act_n  = per_act_q;
    cnt_n      = cnt_q + 1'b1;
    if (!en) begin
      cnt_n     = '0;
      per_act_n = per_pend_q;
    end else if (boundary) begin
      cnt_n     = '0;
      per_act_n = per_pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      per_pend_q <= RST_PERIOD;
      per_act_q  <= RST_PERIOD;
    end else begin
      cnt_q      <= cnt_n;
      per_pend_q <= per_pend_n;
      per_act_q  <= per_act_n;
    end
  end

  assign cnt = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= per_act_q)); // R2
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !boundary) |=> $stable(per_act_q)); // R10
  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/pwmq_compare.sv
module pwmq_compare #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          boundary,
  input  logic          head_valid,
  input  logic [CW-1:0] head_data,
  input  logic [CW-1:0] cnt,
  output logic          pop,
  output logic          pwm_o
);

  logic [CW-1:0] smp_q, smp_n;

  assign pop = boundary && head_valid;

  always_comb begin
    smp_n = smp_q;
    if (pop) smp_n = head_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_n;
  end

  assign pwm_o = en && (cnt < smp_q);

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(smp_q)); // R6
  AST_REUSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !head_valid) |=> $stable(smp_q)); // R5

endmodule

// File: rtl/duty_fifo_pwm.sv
module duty_fifo_pwm #(
  parameter int unsigned   CW         = 16,
  parameter int unsigned   DEPTH      = 4,
  parameter logic [CW-1:0] RST_PERIOD = 16'd255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          smp_we,
  input  logic [CW-1:0] smp_wdata,
  input  logic          per_we,
  input  logic [CW-1:0] per_wdata,
  input  logic [1:0]    wmark,
  output logic [CW-1:0] count_o,
  output logic [1:0]    fill_lvl,
  output logic          room_o,
  output logic          ovf_o,
  output logic          pwm_o
);

  import pwmq_pkg::*;

  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [CW-1:0]    cnt;
  logic             boundary;
  logic             pop;
  logic             head_valid;
  logic [CW-1:0]    head_data;
  logic [OCC_W-1:0] occ;

  pwmq_timebase #(.CW(CW), .RST_PERIOD(RST_PERIOD)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .cnt       (cnt),
    .boundary  (boundary)
  );

  pwmq_fifo #(.DEPTH(DEPTH), .DW(CW)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (smp_we),
    .push_data  (smp_wdata),
    .pop_req    (pop),
    .head_data  (head_data),
    .head_valid (head_valid),
    .occ        (occ),
    .ovf        (ovf_o)
  );

  pwmq_compare #(.CW(CW)) u_compare (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (enable),
    .boundary   (boundary),
    .head_valid (head_valid),
    .head_data  (head_data),
    .cnt        (cnt),
    .pop        (pop),
    .pwm_o      (pwm_o)
  );

  assign count_o  = cnt;
  assign fill_lvl = fill_code(32'(occ));
  assign room_o   = (32'(occ) <= 32'(wmark));

  AST_OUT_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pwm_o); // R11

endmodule

// File: tb/duty_fifo_pwm_tb_top.sv
module duty_fifo_pwm_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        smp_we;
  logic [15:0] smp_wdata;
  logic        per_we;
  logic [15:0] per_wdata;
  logic [1:0]  wmark;
  logic [15:0] count_o;
  logic [1:0]  fill_lvl;
  logic        room_o;
  logic        ovf_o;
  logic        pwm_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  duty_fifo_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .smp_we(smp_we), .smp_wdata(smp_wdata),
    .per_we(per_we), .per_wdata(per_wdata), .wmark(wmark),
    .count_o(count_o), .fill_lvl(fill_lvl), .room_o(room_o),
    .ovf_o(ovf_o), .pwm_o(pwm_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one period of plen cycles starting at a negedge with count 0.
  // s_exp is the sample expected to be active; optional writes at counts.
  task automatic run_period(input int plen, input int s_exp,
                            input int wr_at, input int wr_val,
                            input int per_at, input int per_val,
                            input string req);
    int bad_cnt = 0;
    int bad_shape = 0;
    int highs = 0;
    int exp_hi;
    for (int i = 0; i < plen; i++) begin
      #1;
      if (count_o != 16'(i)) bad_cnt++;
      if (pwm_o !== (i < s_exp)) bad_shape++;
      if (pwm_o) highs++;
      if (i == wr_at)  begin smp_we = 1'b1; smp_wdata = 16'(wr_val); end
      if (i == per_at) begin per_we = 1'b1; per_wdata = 16'(per_val); end
      @(negedge clk);
      smp_we = 1'b0;
      per_we = 1'b0;
    end
    exp_hi = (s_exp < plen) ? s_exp : plen;
    chk(bad_cnt == 0, "R2", "counter sequence mismatches", bad_cnt, 0);
    chk(bad_shape == 0, req, "output shape mismatches", bad_shape, 0);
    chk(highs == exp_hi, "R3", "high cycles in period", highs, exp_hi);
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int prev;
    int vals [5] = '{3, 5, 1, 7, 2};
    rst_n = 1'b0; enable = 1'b0; smp_we = 1'b0; smp_wdata = '0;
    per_we = 1'b0; per_wdata = '0; wmark = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(count_o == 16'd0, "R1", "counter", int'(count_o), 0);
    chk(fill_lvl == 2'd0, "R1", "fill code", int'(fill_lvl), 0);
    chk(ovf_o == 1'b0, "R1", "overflow flag", int'(ovf_o), 0);
    chk(pwm_o == 1'b0, "R1", "output", int'(pwm_o), 0);

    // R10: period written while disabled is active within two cycles
    @(negedge clk);
    per_we = 1'b1; per_wdata = 16'd7;
    @(negedge clk);
    per_we = 1'b0;
    repeat (2) @(negedge clk);

    // R3: sweep every sample from 0 to beyond the terminal value (period 8)
    enable = 1'b1;
    prev = 0;
    for (int s = 0; s <= 9; s++) begin
      run_period(8, prev, 0, s, -1, 0, "R4");
      run_period(8, s, -1, 0, -1, 0, "R3");
      prev = s;
    end

    // R6: raise to 6, then write 2 at count 4 with an empty queue
    run_period(8, 9, 0, 6, -1, 0, "R4");
    run_period(8, 6, 4, 2, -1, 0, "R6");
    run_period(8, 2, -1, 0, -1, 0, "R6");
    // R5: empty queue at period end keeps the sample
    run_period(8, 2, -1, 0, -1, 0, "R5");

    // R10: shrink period mid-run; current period keeps its length
    run_period(8, 2, -1, 0, 2, 4, "R10");
    run_period(5, 2, -1, 0, 0, 7, "R10");
    run_period(8, 2, -1, 0, -1, 0, "R10");

    // R11: disable forces output low at once and clears the counter
    enable = 1'b0;
    #1;
    chk(pwm_o == 1'b0, "R11", "output after disable", int'(pwm_o), 0);
    @(negedge clk);
    #1;
    chk(count_o == 16'd0, "R11", "counter after disable", int'(count_o), 0);

    // R7 R8 R9: fill the queue while disabled, watermark 1
    wmark = 2'd1;
    for (int n = 1; n <= 5; n++) begin
      int occ_exp;
      smp_we = 1'b1; smp_wdata = 16'(vals[n-1]);
      @(negedge clk);
      smp_we = 1'b0;
      #1;
      occ_exp = (n > 4) ? 4 : n;
      chk(fill_lvl == 2'((occ_exp >= 3) ? 3 : occ_exp), "R7", "fill code",
          int'(fill_lvl), (occ_exp >= 3) ? 3 : occ_exp);
      chk(room_o == (occ_exp <= 1), "R9", "room flag",
          int'(room_o), int'(occ_exp <= 1));
      chk(ovf_o == (n > 4), "R8", "overflow flag", int'(ovf_o), int'(n > 4));
      chk((count_o == 16'd0) && (pwm_o == 1'b0), "R11", "idle while disabled",
          int'(count_o), 0);
    end

    // R4 R8 R11: re-enable; retained entries apply in order, fifth dropped
    @(negedge clk);
    enable = 1'b1;
    run_period(8, 2, -1, 0, -1, 0, "R11");
    run_period(8, 3, -1, 0, -1, 0, "R4");
    run_period(8, 5, -1, 0, -1, 0, "R4");
    run_period(8, 1, -1, 0, -1, 0, "R4");
    run_period(8, 7, -1, 0, -1, 0, "R8");
    run_period(8, 7, -1, 0, -1, 0, "R5");
    #1;
    chk(fill_lvl == 2'd0, "R7", "fill code after drain", int'(fill_lvl), 0);
    chk(ovf_o == 1'b1, "R8", "overflow stays set", int'(ovf_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule